// File: doc/BRIEF.md
# Two-Phase Serial Debug Scan Port

This block is a serial access port for test and debug on a chip that runs on two non-overlapping phases. The two phases are modelled as alternating enables, `ph_a` and `ph_b`, on a single clock. A debug controller drives a small set of control pins and a serial data line. Through them it loads a 16-bit scan register one bit at a time, and the register's previous contents come out on a serial output at the same time. On an execute command, the port decodes the scan register and either reads or writes one entry of a small internal debug register file.

The controls (hold, shift, execute, active-low select, serial data in) change during phase A. They are captured during phase B and act during the next A/B pair. The port does nothing unless hold is high and select is low.

The scan register is laid out as follows:
- bits [15:12]: opcode
- bits [11:8]: register index
- bits [7:0]: data byte

A read loads the selected register into the data byte, so the next scan shifts it out first.

Top module: `dbg_scan_port`

## Requirements
- R1: Reset (active-low `rst_n`) clears the scan register and all sixteen 8-bit debug registers to zero, and `dbg_sdo` is low after reset.
- R2: Controls are captured in a phase-B cycle. A shift requested in pair k moves `dbg_sdo` only in the phase A of pair k+1, not in pair k.
- R3: Each honoured shift moves the scan register right by one bit. Bit 0 goes to `dbg_sdo` in the next phase A. `dbg_sdi`, sampled in the phase B of pair k+1, enters bit 15.
- R4: `dbg_sdo` changes only in phase A and keeps its value through the following phase B.
- R5: While the captured select `dbg_sel_n` is high, shift and execute have no effect on the scan register or the debug registers.
- R6: While the captured `dbg_hold` is low, shift and execute have no effect.
- R7: Executing opcode 2 writes bits [7:0] into the debug register selected by bits [11:8].
- R8: Executing opcode 1 replaces bits [7:0] with the selected debug register and leaves bits [15:8] unchanged.
- R9: Executing opcode 0 or any opcode from 3 to 15 changes neither the scan register nor the debug registers.
- R10: When shift and execute are both requested in one pair, only the execute is performed. No bit is shifted in that pair.
- R11: The scan register and debug registers update only on phase-B cycles, and `dbg_sdo` updates only on phase-A cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ph_a | input | 1 | Phase-A enable |
| ph_b | input | 1 | Phase-B enable |
| dbg_hold | input | 1 | Must be high for any command to be honoured |
| dbg_shift | input | 1 | Request a one-bit shift |
| dbg_exec | input | 1 | Request decode of the scan register |
| dbg_sel_n | input | 1 | Active-low select; high freezes the port |
| dbg_sdi | input | 1 | Serial data in |
| dbg_sdo | output | 1 | Serial data out |

## Verification
A control set in pair k is latched at that pair's phase-B edge. Its effect on `dbg_sdo` is due at the phase-A edge of pair k+1, and its effect on the scan register and the registers is due at the phase-B edge of pair k+1. The bench therefore drives every input at the falling edge that opens a phase A. It reads `dbg_sdo` at the falling edge inside the following phase B, which is one full pair after the shift request, and checks it again just after the phase-B edge. Effects on internal state are observed only through a later scan-out, which shifts the whole 16-bit word out and compares it with a model kept in the bench.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int SCAN_W = 16;
  localparam int OPC_W  = 4;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [OPC_W-1:0] OPC_NOP = 4'd0;
  localparam logic [OPC_W-1:0] OPC_RD  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_WR  = 4'd2;

  typedef struct packed {
    logic hold;
    logic shift;
    logic exec;
    logic sel_n;
  } ctl_t;
endpackage

// File: rtl/dbg_ctl_latch.sv
module dbg_ctl_latch
  import dbg_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ph_b,
  input  ctl_t ctl_in,
  output ctl_t ctl_q,
  output logic shift_go,
  output logic exec_go
);
  ctl_t ctl_d;
  logic enabled;

  always_comb begin
    ctl_d = ctl_q;
    if (ph_b) ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.hold  <= 1'b0;
      ctl_q.shift <= 1'b0;
      ctl_q.exec  <= 1'b0;
      ctl_q.sel_n <= 1'b1;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    enabled  = ctl_q.hold & ~ctl_q.sel_n;
    exec_go  = enabled & ctl_q.exec;
    shift_go = enabled & ctl_q.shift & ~ctl_q.exec;
  end
endmodule

// File: rtl/dbg_exec_decode.sv
module dbg_exec_decode
  import dbg_scan_pkg::*;
#(
  parameter int OP_W = OPC_W
) (
  input  logic            ph_b,
  input  logic            exec_go,
  input  logic [OP_W-1:0] opcode,
  output logic            wr_en,
  output logic            rd_en
);
  logic act;

  always_comb begin
    act   = ph_b & exec_go;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (act) begin
      case (opcode)
        OP_W'(OPC_RD): rd_en = 1'b1;
        OP_W'(OPC_WR): wr_en = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg #(
  parameter int SR_W = 16,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ph_a,
  input  logic            ph_b,
  input  logic            shift_go,
  input  logic            rd_en,
  input  logic [DW-1:0]   rd_data,
  input  logic            sdi,
  output logic [SR_W-1:0] sr_q,
  output logic            sdo
);
  logic [SR_W-1:0] sr_d;
  logic            sdo_d;

  always_comb begin
    sr_d = sr_q;
    if (ph_b) begin
      if (rd_en)         sr_d[DW-1:0] = rd_data;
      else if (shift_go) sr_d = {sdi, sr_q[SR_W-1:1]};
    end
  end

  always_comb begin
    sdo_d = sdo;
    if (ph_a && shift_go) sdo_d = sr_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      sdo  <= 1'b0;
    end else begin
      sr_q <= sr_d;
      sdo  <= sdo_d;
    end
  end
endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file #(
  parameter int IW = 4,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  output logic [(1<<IW)*DW-1:0] regs_flat
);
  localparam int NREGS = 1 << IW;

  logic [DW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] reg_d;

    always_comb begin
      reg_d = regs_q[g];
      if (wr_en && (idx == IW'(g))) reg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= reg_d;
    end

    assign regs_flat[g*DW +: DW] = regs_q[g];
  end

  assign rd_data = regs_q[idx];
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
  import dbg_scan_pkg::*;
#(
  parameter int SR_W = SCAN_W,
  parameter int OP_W = OPC_W,
  parameter int IW   = IDX_W,
  parameter int DW   = BYTE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_a,
  input  logic ph_b,
  input  logic dbg_hold,
  input  logic dbg_shift,
  input  logic dbg_exec,
  input  logic dbg_sel_n,
  input  logic dbg_sdi,
  output logic dbg_sdo
);
  localparam int IDX_LSB = DW;
  localparam int OP_LSB  = DW + IW;
  localparam int NREGS   = 1 << IW;

  logic [1:0]           rst_sync;
  logic                 rst_sync_n;
  ctl_t                 ctl_in;
  ctl_t                 ctl_q;
  logic                 hold_q;
  logic                 sel_n_q;
  logic                 shift_go;
  logic                 exec_go;
  logic                 wr_en;
  logic                 rd_en;
  logic [SR_W-1:0]      sr_q;
  logic [DW-1:0]        rd_data;
  logic [NREGS*DW-1:0]  regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    ctl_in.hold  = dbg_hold;
    ctl_in.shift = dbg_shift;
    ctl_in.exec  = dbg_exec;
    ctl_in.sel_n = dbg_sel_n;
  end

  dbg_ctl_latch u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ph_b     (ph_b),
    .ctl_in   (ctl_in),
    .ctl_q    (ctl_q),
    .shift_go (shift_go),
    .exec_go  (exec_go)
  );

  assign hold_q  = ctl_q.hold;
  assign sel_n_q = ctl_q.sel_n;

  dbg_exec_decode #(.OP_W(OP_W)) u_dec (
    .ph_b    (ph_b),
    .exec_go (exec_go),
    .opcode  (sr_q[OP_LSB +: OP_W]),
    .wr_en   (wr_en),
    .rd_en   (rd_en)
  );

  dbg_shift_reg #(.SR_W(SR_W), .DW(DW)) u_sr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ph_a     (ph_a),
    .ph_b     (ph_b),
    .shift_go (shift_go),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .sdi      (dbg_sdi),
    .sr_q     (sr_q),
    .sdo      (dbg_sdo)
  );

  dbg_reg_file #(.IW(IW), .DW(DW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .idx       (sr_q[IDX_LSB +: IW]),
    .wr_data   (sr_q[DW-1:0]),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );
endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk #(
  parameter int SR_W  = 16,
  parameter int DW    = 8,
  parameter int NREGS = 16
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                ph_a,
  input logic                ph_b,
  input logic                dbg_sdo,
  input logic [SR_W-1:0]     sr_q,
  input logic [NREGS*DW-1:0] regs_flat,
  input logic                wr_en,
  input logic                rd_en,
  input logic                hold_q,
  input logic                sel_n_q
);
  AST_SDO_ONLY_PH_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ph_a |=> $stable(dbg_sdo)); // R4

  AST_SCAN_ONLY_PH_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ph_b |=> $stable(sr_q)); // R11

  AST_SEL_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ph_b && sel_n_q) |=> ($stable(sr_q) && $stable(regs_flat))); // R5

  AST_HOLD_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ph_b && !hold_q) |=> ($stable(sr_q) && $stable(regs_flat))); // R6

  AST_REGS_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(regs_flat)); // R7

  AST_RD_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> $stable(sr_q[SR_W-1:DW])); // R8

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({wr_en, rd_en})); // R9
endmodule

bind dbg_scan_port dbg_scan_port_chk #(.SR_W(SR_W), .DW(DW), .NREGS(NREGS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ph_a       (ph_a),
  .ph_b       (ph_b),
  .dbg_sdo    (dbg_sdo),
  .sr_q       (sr_q),
  .regs_flat  (regs_flat),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .hold_q     (hold_q),
  .sel_n_q    (sel_n_q)
);

// File: tb/test_dbg_scan_port.sv
module test_dbg_scan_port;
  logic clk = 1'b0;
  logic rst_n, ph_a, ph_b;
  logic hold, shift, exec_r, sel_n, sdi;
  logic sdo;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] exp_sr;
  logic [7:0]  exp_regs [16];
  logic        last_sdo;

  always #2.5 clk = ~clk;

  dbg_scan_port i_dbg_scan_port (
    .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b),
    .dbg_hold(hold), .dbg_shift(shift), .dbg_exec(exec_r),
    .dbg_sel_n(sel_n), .dbg_sdi(sdi), .dbg_sdo(sdo)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One A/B pair: inputs driven at the start of A, sdo sampled inside B.
  task automatic pair(input logic h, s, e, sn, di, output logic o);
    @(negedge clk);
    ph_a = 1'b1; ph_b = 1'b0;
    hold = h; shift = s; exec_r = e; sel_n = sn; sdi = di;
    @(posedge clk);
    @(negedge clk);
    ph_a = 1'b0; ph_b = 1'b1;
    o = sdo;
    @(posedge clk);
  endtask

  task automatic model_reset();
    exp_sr = '0;
    for (int i = 0; i < 16; i++) exp_regs[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ph_a = 1'b0; ph_b = 1'b0;
    hold = 1'b0; shift = 1'b0; exec_r = 1'b0; sel_n = 1'b1; sdi = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    model_reset();
  endtask

  // Shift in w (LSB first) while shifting out and checking the old contents.
  task automatic scan_word(input logic [15:0] w, input string req);
    logic [15:0] got;
    logic o;
    for (int p = 0; p <= 16; p++) begin
      pair(1'b1, (p < 16), 1'b0, 1'b0, (p >= 1) ? w[p-1] : 1'b0, o);
      if (p >= 1) got[p-1] = o;
    end
    chk(req, got, exp_sr);
    last_sdo = got[15];
    exp_sr = w;
  endtask

  task automatic exec_cmd(input logic h, input logic sn, input logic with_shift);
    logic o;
    pair(h, with_shift, 1'b1, sn, 1'b0, o);
    pair(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, o);
    if (h && !sn) begin
      case (exp_sr[15:12])
        4'd1: exp_sr[7:0] = exp_regs[exp_sr[11:8]];
        4'd2: exp_regs[exp_sr[11:8]] = exp_sr[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sdo after reset", {15'd0, sdo}, 16'h0000);
    scan_word({4'd1, 4'd15, 8'h00}, "R1 scan register cleared");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd1, 4'd0, 8'h00}, "R1 reg15 cleared");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word(16'h0000, "R1 reg0 cleared");
  endtask

  task automatic t_write_read();
    scan_word({4'd2, 4'd5, 8'hA5}, "R3 scan pattern");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd2, 4'd15, 8'h3C}, "R7 write reg5 leaves scan word");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd2, 4'd0, 8'hC3}, "R7 write reg15");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd1, 4'd5, 8'hFF}, "R7 write reg0");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd1, 4'd15, 8'h00}, "R8 read reg5 into low byte");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd1, 4'd0, 8'h11}, "R8 read reg15");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word(16'hBEEF, "R8 read reg0");
    scan_word(16'h1234, "R3 arbitrary pattern BEEF");
  endtask

  task automatic t_latency();
    logic o1, o2;
    scan_word(16'h0001, "R3 pattern 1234");
    pair(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, o1);
    chk("R2 sdo not moved in request pair", {15'd0, o1}, {15'd0, last_sdo});
    pair(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, o2);
    chk("R2 sdo moved in next pair", {15'd0, o2}, 16'h0001);
    #1;
    chk("R4 sdo held through phase B", {15'd0, sdo}, 16'h0001);
    exp_sr = 16'h8000;
    scan_word(16'h0000, "R3 sdi entered bit 15");
  endtask

  task automatic t_freeze(input logic use_hold, input string req);
    logic o;
    scan_word({4'd2, 4'd2, 8'h77}, {req, " setup"});
    for (int i = 0; i < 3; i++)
      pair(use_hold ? 1'b0 : 1'b1, 1'b1, 1'b0, use_hold ? 1'b0 : 1'b1, 1'b1, o);
    exec_cmd(use_hold ? 1'b0 : 1'b1, use_hold ? 1'b0 : 1'b1, 1'b0);
    scan_word({4'd1, 4'd2, 8'h00}, {req, " scan word unchanged"});
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word(16'h0000, {req, " reg2 not written"});
  endtask

  task automatic t_nop();
    scan_word({4'd0, 4'd4, 8'h99}, "R9 setup");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd7, 4'd4, 8'h55}, "R9 opcode 0 no change");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word({4'd1, 4'd4, 8'h00}, "R9 opcode 7 no change");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word(16'h0000, "R9 reg4 still zero");
  endtask

  task automatic t_priority();
    scan_word({4'd1, 4'd5, 8'h00}, "R10 setup");
    exec_cmd(1'b1, 1'b0, 1'b1);
    scan_word(16'h0000, "R10 execute wins, no shift");
  endtask

  task automatic t_reset_mid();
    scan_word({4'd2, 4'd3, 8'h5A}, "R1 mid setup");
    exec_cmd(1'b1, 1'b0, 1'b0);
    do_reset();
    scan_word({4'd1, 4'd3, 8'h00}, "R1 scan cleared by reset");
    exec_cmd(1'b1, 1'b0, 1'b0);
    scan_word(16'h0000, "R1 reg3 cleared by reset");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_write_read();
    t_latency();
    t_freeze(1'b0, "R5");
    t_freeze(1'b1, "R6");
    t_nop();
    t_priority();
    t_reset_mid();
    summary();
    $finish;
  end
endmodule